// File: doc/BRIEF.md
# Compare, Skip and Jump Condition Unit

This unit decides whether an instruction from the arithmetic-test families of a 36-bit two's-complement machine skips or jumps. One request carries an instruction class, a 3-bit condition code, the accumulator value, an operand (an immediate or a memory word) and a flag that marks an accumulator field of zero. The unit does four things:

- It picks the value under test. For some classes it first adds +1 or -1 to that value.
- It compares the value against zero, or compares the accumulator against the operand.
- It returns the taken decision and the resulting value.
- It returns the write-back enables for the accumulator and the memory word. For increment and decrement it also returns carry and overflow.

Requests enter through a valid/ready port and are held in one register stage. Results are driven combinationally from that stage while `out_valid` is high. A request is accepted when `in_valid` and `in_ready` are both high at a rising clock edge. A result is consumed when `out_valid` and `out_ready` are both high at a rising clock edge. While the consumer holds `out_ready` low, the pending result and all its outputs stay unchanged, and `in_ready` stays low. The stage accepts a new request in the same cycle that the old result is consumed, so it sustains one request per clock.

Top module: `cond_skip_unit`

## Requirements
- R1: `in_ready` equals `!out_valid || out_ready`. A request accepted at one edge is presented with `out_valid` high from that edge on. A result not consumed keeps `out_valid` and every result output unchanged.
- R2: The condition codes have the following meanings:
  - 0: never
  - 1: less than zero
  - 2: equal to zero
  - 3: less than or equal to zero
  - 4: always
  - 5: greater than or equal to zero
  - 6: not zero
  - 7: greater than zero
- R3: Class 0 (compare) tests the signed difference accumulator minus operand, formed one bit wider so it never wraps. `result` is the accumulator. No write enable, carry or overflow is raised.
- R4: Class 1 (skip) tests the memory word (`opnd`). `result` is that word. `wr_mem` is 0, and `wr_ac` is 1 exactly when `ac_field_zero` is 0.
- R5: Classes 2 and 3 (increment-and-skip and decrement-and-skip) add +1 or -1 to the memory word and test the new value. `result` is the new value, `wr_mem` is 1, and `wr_ac` is 1 exactly when `ac_field_zero` is 0.
- R6: Class 4 (jump) tests the accumulator. `result` is the accumulator, and no write enable is raised.
- R7: Classes 5 and 6 (increment-and-jump and decrement-and-jump) add +1 or -1 to the accumulator and test the new value. `result` is the new value, `wr_ac` is 1 and `wr_mem` is 0.
- R8: Condition 0 never sets `taken`. The arithmetic result and the write enables of the class are still produced.
- R9: Carry is the carry out of bit 35 of the 36-bit add. Adding +1 gives carry only for the all-ones value; adding -1 gives carry for any nonzero value. Overflow is raised when +1 is added to the largest positive value, or when -1 is added to the most negative value. Classes without arithmetic give carry 0 and overflow 0.
- R10: Class 7 is reserved. It gives `taken` 0, no write enables and `result` equal to the accumulator.
- R11: After reset `out_valid` is 0. `taken`, `wr_ac` and `wr_mem` are 0 whenever `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Stage can accept a request |
| in_class | input | 3 | Instruction class (0 compare, 1 skip, 2 inc-skip, 3 dec-skip, 4 jump, 5 inc-jump, 6 dec-jump, 7 reserved) |
| in_cond | input | 3 | Condition code (R2) |
| in_ac | input | 36 | Accumulator value |
| in_opnd | input | 36 | Immediate or memory word |
| in_ac_field_zero | input | 1 | Accumulator field of the instruction is zero |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| taken | output | 1 | Skip or jump is taken |
| result | output | 36 | Value tested or produced |
| wr_ac | output | 1 | Write `result` to the accumulator |
| wr_mem | output | 1 | Write `result` to the memory word |
| carry | output | 1 | Carry out of the increment or decrement |
| ovf | output | 1 | Signed overflow of the increment or decrement |

## Verification
Every result of a request accepted at a rising edge is due right after that edge, through exactly one register. The result then stays put for as many cycles as `out_ready` is held low. The bench drives inputs and samples outputs on the falling edge. Its model advances its own held request at each rising edge by the same acceptance rule, so the two are compared in every cycle, including back-pressure cycles and idle gaps. Directed sweeps cover every class and condition against zero, ±1 and both extreme values; a random phase with random `out_ready` then exercises stalls.

// File: rtl/csu_pkg.sv
package csu_pkg;
  typedef enum logic [2:0] {
    CLS_CMP      = 3'd0,
    CLS_SKIP     = 3'd1,
    CLS_INC_SKIP = 3'd2,
    CLS_DEC_SKIP = 3'd3,
    CLS_JUMP     = 3'd4,
    CLS_INC_JUMP = 3'd5,
    CLS_DEC_JUMP = 3'd6,
    CLS_RSVD     = 3'd7
  } op_class_e;

  localparam logic [2:0] CND_NEVER  = 3'd0;
  localparam logic [2:0] CND_ALWAYS = 3'd4;
endpackage

// File: rtl/csu_hold_stage.sv
module csu_hold_stage #(
  parameter int WORD_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [2:0]        in_class,
  input  logic [2:0]        in_cond,
  input  logic [WORD_W-1:0] in_ac,
  input  logic [WORD_W-1:0] in_opnd,
  input  logic              in_acz,
  input  logic              out_ready,
  output logic              q_valid,
  output logic [2:0]        q_class,
  output logic [2:0]        q_cond,
  output logic [WORD_W-1:0] q_ac,
  output logic [WORD_W-1:0] q_opnd,
  output logic              q_acz
);
  assign in_ready = !q_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_class <= '0;
      q_cond  <= '0;
      q_ac    <= '0;
      q_opnd  <= '0;
      q_acz   <= 1'b0;
    end else if (in_ready) begin
      q_valid <= in_valid;
      if (in_valid) begin
        q_class <= in_class;
        q_cond  <= in_cond;
        q_ac    <= in_ac;
        q_opnd  <= in_opnd;
        q_acz   <= in_acz;
      end
    end
  end

  // R1: a stalled result keeps its contents
  a_r1_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    q_valid && !out_ready |=> q_valid && $stable(q_ac) && $stable(q_opnd)
      && $stable(q_class) && $stable(q_cond) && $stable(q_acz));
endmodule

// File: rtl/csu_arith.sv
module csu_arith
  import csu_pkg::*;
#(
  parameter int WORD_W = 36
) (
  input  logic [2:0]        cls,
  input  logic [WORD_W-1:0] ac,
  input  logic [WORD_W-1:0] opnd,
  input  logic              acz,
  output logic [WORD_W-1:0] value,
  output logic              carry,
  output logic              ovf,
  output logic              wr_ac_raw,
  output logic              wr_mem_raw
);
  localparam int SUM_W = WORD_W + 1;

  logic              use_mem, do_inc, do_dec, is_arith;
  logic [WORD_W-1:0] base, addend;
  logic [SUM_W-1:0]  sum;

  always_comb begin
    use_mem    = 1'b0;
    do_inc     = 1'b0;
    do_dec     = 1'b0;
    wr_ac_raw  = 1'b0;
    wr_mem_raw = 1'b0;
    unique case (op_class_e'(cls))
      CLS_SKIP:     begin use_mem = 1'b1; wr_ac_raw = !acz; end
      CLS_INC_SKIP: begin use_mem = 1'b1; do_inc = 1'b1; wr_ac_raw = !acz; wr_mem_raw = 1'b1; end
      CLS_DEC_SKIP: begin use_mem = 1'b1; do_dec = 1'b1; wr_ac_raw = !acz; wr_mem_raw = 1'b1; end
      CLS_INC_JUMP: begin do_inc = 1'b1; wr_ac_raw = 1'b1; end
      CLS_DEC_JUMP: begin do_dec = 1'b1; wr_ac_raw = 1'b1; end
      default:      ;
    endcase
  end

  assign is_arith = do_inc || do_dec;
  assign base     = use_mem ? opnd : ac;
  assign addend   = do_dec ? {WORD_W{1'b1}}
                  : (do_inc ? {{(WORD_W-1){1'b0}}, 1'b1} : '0);
  assign sum      = {1'b0, base} + {1'b0, addend};
  assign value    = sum[WORD_W-1:0];
  assign carry    = is_arith && sum[WORD_W];
  assign ovf      = is_arith && (base[WORD_W-1] == addend[WORD_W-1])
                             && (sum[WORD_W-1] != base[WORD_W-1]);
endmodule

// File: rtl/csu_decide.sv
module csu_decide
  import csu_pkg::*;
#(
  parameter int WORD_W = 36
) (
  input  logic [2:0]        cls,
  input  logic [2:0]        cond,
  input  logic [WORD_W-1:0] value,
  input  logic [WORD_W-1:0] ac,
  input  logic [WORD_W-1:0] opnd,
  output logic              taken_raw
);
  localparam int DIFF_W = WORD_W + 1;

  logic [DIFF_W-1:0] diff;
  logic              is_lt, is_eq, hit;

  assign diff = {ac[WORD_W-1], ac} - {opnd[WORD_W-1], opnd};

  always_comb begin
    if (op_class_e'(cls) == CLS_CMP) begin
      is_lt = diff[DIFF_W-1];
      is_eq = (diff == '0);
    end else begin
      is_lt = value[WORD_W-1];
      is_eq = (value == '0);
    end
    unique case (cond)
      3'd0: hit = 1'b0;
      3'd1: hit = is_lt;
      3'd2: hit = is_eq;
      3'd3: hit = is_lt || is_eq;
      3'd4: hit = 1'b1;
      3'd5: hit = !is_lt;
      3'd6: hit = !is_eq;
      default: hit = !is_lt && !is_eq;
    endcase
    taken_raw = hit && (op_class_e'(cls) != CLS_RSVD);
  end
endmodule

// File: rtl/cond_skip_unit.sv
module cond_skip_unit
  import csu_pkg::*;
#(
  parameter int WORD_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [2:0]        in_class,
  input  logic [2:0]        in_cond,
  input  logic [WORD_W-1:0] in_ac,
  input  logic [WORD_W-1:0] in_opnd,
  input  logic              in_ac_field_zero,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              taken,
  output logic [WORD_W-1:0] result,
  output logic              wr_ac,
  output logic              wr_mem,
  output logic              carry,
  output logic              ovf
);
  logic [2:0]        q_class, q_cond;
  logic [WORD_W-1:0] q_ac, q_opnd, value;
  logic              q_acz, taken_raw, wr_ac_raw, wr_mem_raw;

  csu_hold_stage #(.WORD_W(WORD_W)) u_stage (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_class(in_class), .in_cond(in_cond), .in_ac(in_ac), .in_opnd(in_opnd),
    .in_acz(in_ac_field_zero), .out_ready(out_ready), .q_valid(out_valid),
    .q_class(q_class), .q_cond(q_cond), .q_ac(q_ac), .q_opnd(q_opnd), .q_acz(q_acz)
  );

  csu_arith #(.WORD_W(WORD_W)) u_arith (
    .cls(q_class), .ac(q_ac), .opnd(q_opnd), .acz(q_acz), .value(value),
    .carry(carry), .ovf(ovf), .wr_ac_raw(wr_ac_raw), .wr_mem_raw(wr_mem_raw)
  );

  csu_decide #(.WORD_W(WORD_W)) u_decide (
    .cls(q_class), .cond(q_cond), .value(value), .ac(q_ac), .opnd(q_opnd),
    .taken_raw(taken_raw)
  );

  assign result = value;
  assign taken  = out_valid && taken_raw;
  assign wr_ac  = out_valid && wr_ac_raw;
  assign wr_mem = out_valid && wr_mem_raw;

  // R8: condition 0 never takes
  a_r8_never_taken: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && q_cond == CND_NEVER |-> !taken);
  // R2: condition 4 always takes for defined classes
  a_r2_always_taken: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && q_cond == CND_ALWAYS && q_class != CLS_RSVD |-> taken);
  // R6, R3: compare and jump write nothing
  a_r6_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (q_class == CLS_JUMP || q_class == CLS_CMP) |-> !wr_ac && !wr_mem);
  // R7: increment/decrement-and-jump write only the accumulator
  a_r7_ac_only: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (q_class == CLS_INC_JUMP || q_class == CLS_DEC_JUMP) |-> wr_ac && !wr_mem);
  // R5: increment/decrement-and-skip store the memory word
  a_r5_mem_store: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (q_class == CLS_INC_SKIP || q_class == CLS_DEC_SKIP) |-> wr_mem);
  // R10: reserved class is inert
  a_r10_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && q_class == CLS_RSVD |-> !taken && !wr_ac && !wr_mem && !carry && !ovf);
  // R1: a stalled result keeps the outputs
  a_r1_out_stable: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(result) && $stable(taken));
endmodule

// File: tb/cond_skip_unit_tb.sv
module cond_skip_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 36;
  localparam int N_DIR = 2304;
  localparam int N_RND = 3000;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready, in_acz = 1'b0;
  logic [2:0] in_class = '0, in_cond = '0;
  logic [W-1:0] in_ac = '0, in_opnd = '0;
  logic out_valid, out_ready = 1'b1, taken, wr_ac, wr_mem, carry, ovf;
  logic [W-1:0] result;

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cond_skip_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_class(in_class), .in_cond(in_cond), .in_ac(in_ac), .in_opnd(in_opnd),
    .in_ac_field_zero(in_acz), .out_valid(out_valid), .out_ready(out_ready),
    .taken(taken), .result(result), .wr_ac(wr_ac), .wr_mem(wr_mem),
    .carry(carry), .ovf(ovf)
  );

  task automatic check(input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] pick(input int k);
    case (k % 6)
      0: return '0;
      1: return 36'd1;
      2: return {W{1'b1}};
      3: return {1'b0, {(W-1){1'b1}}};
      4: return {1'b1, {(W-1){1'b0}}};
      default: return 36'h123456789;
    endcase
  endfunction

  // Behavioural reference for one held request
  task automatic model(input int cls, input int cnd, input logic [W-1:0] ac,
                       input logic [W-1:0] op, input bit acz, output bit t,
                       output logic [W-1:0] res, output bit wa, output bit wm,
                       output bit c, output bit o, output string req);
    longint sv, sa, so;
    bit lt, eq;
    logic [W-1:0] base;
    int delta;
    wa = 0; wm = 0; c = 0; o = 0; delta = 0; base = ac;
    case (cls)
      0: req = "R3";
      1: begin req = "R4"; base = op; wa = !acz; end
      2: begin req = "R5"; base = op; delta = 1;  wa = !acz; wm = 1; end
      3: begin req = "R5"; base = op; delta = -1; wa = !acz; wm = 1; end
      4: req = "R6";
      5: begin req = "R7"; delta = 1;  wa = 1; end
      6: begin req = "R7"; delta = -1; wa = 1; end
      default: req = "R10";
    endcase
    if (delta == 1) begin
      res = base + 36'd1;
      c = (base == {W{1'b1}});
      o = (base == {1'b0, {(W-1){1'b1}}});
    end else if (delta == -1) begin
      res = base - 36'd1;
      c = (base != '0);
      o = (base == {1'b1, {(W-1){1'b0}}});
    end else res = base;
    if (cls == 0) begin
      sa = longint'($signed(ac));
      so = longint'($signed(op));
      lt = (sa - so) < 0;
      eq = (sa == so);
    end else begin
      sv = longint'($signed(res));
      lt = sv < 0;
      eq = sv == 0;
    end
    case (cnd)
      0: t = 0;
      1: t = lt;
      2: t = eq;
      3: t = lt || eq;
      4: t = 1;
      5: t = !lt;
      6: t = !eq;
      default: t = !lt && !eq;
    endcase
    if (cls == 7) t = 0;
    if (cnd == 0) req = {req, "/R8"};
  endtask

  initial begin : main
    bit mvalid;
    int mcls, mcnd;
    logic [W-1:0] mac, mop;
    bit macz, et, ewa, ewm, ec, eo, eready;
    logic [W-1:0] eres;
    string req;
    mvalid = 0; mcls = 0; mcnd = 0; mac = '0; mop = '0; macz = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R11", "out_valid in reset", {35'd0, out_valid}, '0);
    rst_n = 1'b1;
    for (int i = 0; i < N_DIR + N_RND; i++) begin
      @(negedge clk);
      // compare state produced by the last edge
      check("R11/R1", "out_valid", {35'd0, out_valid}, {35'd0, mvalid});
      if (mvalid) begin
        model(mcls, mcnd, mac, mop, macz, et, eres, ewa, ewm, ec, eo, req);
        check({"R2/", req}, "taken", {35'd0, taken}, {35'd0, et});
        check(req, "result", result, eres);
        check(req, "wr_ac", {35'd0, wr_ac}, {35'd0, ewa});
        check(req, "wr_mem", {35'd0, wr_mem}, {35'd0, ewm});
        check("R9", "carry", {35'd0, carry}, {35'd0, ec});
        check("R9", "ovf", {35'd0, ovf}, {35'd0, eo});
      end else begin
        check("R11", "idle strobes", {33'd0, taken, wr_ac, wr_mem}, '0);
      end
      // new stimulus
      if (i < N_DIR) begin
        in_valid = 1'b1;
        out_ready = (i % 17) != 5;
        in_class = 3'(i % 8);
        in_cond = 3'((i / 8) % 8);
        in_ac = pick(i / 64);
        in_opnd = pick((i / 64) + (i / 384));
        in_acz = (i % 3) == 0;
      end else begin
        in_valid = ($urandom % 4) != 0;
        out_ready = ($urandom % 3) != 0;
        in_class = 3'($urandom % 8);
        in_cond = 3'($urandom % 8);
        in_ac = ($urandom % 4 == 0) ? pick($urandom) : {4'($urandom), 32'($urandom)};
        in_opnd = ($urandom % 4 == 0) ? pick($urandom) : {4'($urandom), 32'($urandom)};
        in_acz = $urandom % 2;
      end
      #1;
      eready = !mvalid || out_ready;
      check("R1", "in_ready", {35'd0, in_ready}, {35'd0, eready});
      if (mvalid && out_ready) mvalid = 0;
      if (in_valid && eready) begin
        mvalid = 1; mcls = int'(in_class); mcnd = int'(in_cond);
        mac = in_ac; mop = in_opnd; macz = in_acz;
      end
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule